// File: doc/BRIEF.md
# Memory-Mapped Character Terminal

This block gives a processor a character terminal seen through four 32-bit registers on a simple bus. The bus carries an address, a read strobe, a write strobe, write data and read data. Read data is combinational in the cycle the read strobe is high. All side effects of an access take effect at the clock edge that ends that cycle. Each register sits at a fixed address above a base address, which is 32'hFFFF0000 by default.

The input side takes 8-bit characters from a keyboard source as a one-cycle valid pulse with a data byte. It holds the last character and raises a ready flag until software reads the character. The output side presents a written character to a display sink with a valid/ready handshake. Its ready flag tells software when another character may be written. Each side has its own interrupt enable and its own interrupt request line. The two sides share nothing: a received character only reaches the display if software copies it across.

Top module: `term_mmio`

## Requirements
- R1: After reset the input ready flag, the overrun flag and both interrupt enables are 0, the output ready flag is 1, `disp_valid` is 0 and both interrupt lines are 0.
- R2: The input status register is at base+0x0, input data at base+0x4, output status at base+0x8 and output data at base+0xC. A read from any other address returns 0, and a write to any other address changes no state.
- R3: A cycle with `kbd_valid` high stores `kbd_data` and sets input ready (status bit 0). The input data register then reads the byte in bits 7:0 with bits 31:8 zero.
- R4: A read of input data clears input ready at the closing edge. If a new character arrives in the same cycle, the read returns the older byte and ready stays 1.
- R5: A character that arrives while input ready is 1 replaces the held byte and sets the overrun flag in input status bit 2. A read of input status clears the overrun flag. An arrival in the same cycle wins over that clear. An arrival in the same cycle as an input data read sets no overrun.
- R6: Status bit 1 of each side is an interrupt enable that can be written and read back. Writes to the ready and overrun bits and to all other status bits are ignored, and unused bits read 0.
- R7: A write to output data while output ready is 1 stores the byte. From the next cycle `disp_valid` is 1 with the byte on `disp_data` and output ready reads 0. These hold until a cycle in which `disp_ready` is 1. After that cycle output ready is 1 and `disp_valid` is 0. The output data register reads back the last accepted byte in bits 7:0.
- R8: A write to output data while output ready is 0 is ignored: `disp_data` and the output data register keep the pending byte.
- R9: Each interrupt line is high exactly while its side's ready flag and interrupt enable are both 1.
- R10: An arriving character never raises `disp_valid` and never changes output state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| kbd_valid | input | 1 | One-cycle pulse for an arriving character |
| kbd_data | input | 8 | Arriving character |
| disp_valid | output | 1 | Character pending for the display |
| disp_data | output | 8 | Pending character |
| disp_ready | input | 1 | Display takes the pending character |
| rx_irq | output | 1 | Input-side interrupt request |
| tx_irq | output | 1 | Output-side interrupt request |

## Verification
A stuck or wrongly updated flag shows up at the status registers on the first read after the event. It also shows on the interrupt lines one edge after the event, because both lines follow the stored flags without delay. A held byte that is corrupted or changed by a write that should have been ignored appears on `disp_data`, or in the data register's read value, in the very next cycle. The sweeps pass all 256 character codes through both sides, so a dropped or swapped data bit is exposed directly.

// File: rtl/term_pkg.sv
package term_pkg;
  localparam int unsigned NUM_REGS   = 4;
  localparam int unsigned REG_STRIDE = 4;
  localparam int unsigned BUS_W      = 32;

  typedef enum logic [1:0] {
    SEL_RX_STAT = 2'd0,
    SEL_RX_DATA = 2'd1,
    SEL_TX_STAT = 2'd2,
    SEL_TX_DATA = 2'd3
  } term_sel_e;

  localparam int unsigned BIT_RDY = 0;
  localparam int unsigned BIT_IE  = 1;
  localparam int unsigned BIT_OVR = 2;
endpackage

// File: rtl/term_rst_sync.sv
module term_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/term_decode.sv
module term_decode
  import term_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF0000
) (
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [NUM_REGS-1:0] wr_sel
);
  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + ADDR_W'(g * REG_STRIDE);
    assign hit[g] = (bus_addr == REG_ADDR);
  end

  always_comb begin
    rd_sel = hit & {NUM_REGS{bus_rd}};
    wr_sel = hit & {NUM_REGS{bus_wr}};
  end
endmodule

// File: rtl/term_rx.sv
module term_rx #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              rd_data_stb,
  input  logic              rd_stat_stb,
  input  logic              wr_stat_stb,
  input  logic              wr_ie,
  output logic              rdy,
  output logic              ie,
  output logic              ovr,
  output logic [CHAR_W-1:0] data,
  output logic              irq
);
  logic              rdy_q, rdy_d;
  logic              ovr_q, ovr_d;
  logic              ie_q;
  logic [CHAR_W-1:0] data_q;
  logic              data_en;

  always_comb begin
    rdy_d = rdy_q;
    if (rd_data_stb) rdy_d = 1'b0;
    if (in_valid)    rdy_d = 1'b1;

    ovr_d = ovr_q;
    if (rd_stat_stb) ovr_d = 1'b0;
    if (in_valid && rdy_q && !rd_data_stb) ovr_d = 1'b1;

    data_en = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      if (wr_stat_stb) ie_q <= wr_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= in_data;
    end
  end

  assign rdy  = rdy_q;
  assign ie   = ie_q;
  assign ovr  = ovr_q;
  assign data = data_q;
  assign irq  = rdy_q & ie_q;
endmodule

// File: rtl/term_tx.sv
module term_tx #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data_stb,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              wr_stat_stb,
  input  logic              wr_ie,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              rdy,
  output logic              ie,
  output logic              irq
);
  logic              rdy_q, rdy_d;
  logic              ie_q;
  logic [CHAR_W-1:0] data_q;
  logic              load_en;

  always_comb begin
    load_en = wr_data_stb && rdy_q;
    rdy_d   = rdy_q;
    if (load_en)                 rdy_d = 1'b0;
    else if (!rdy_q && out_ready) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b1;
      ie_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      if (wr_stat_stb) ie_q <= wr_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_en) begin
      data_q <= wr_data;
    end
  end

  assign out_valid = ~rdy_q;
  assign out_data  = data_q;
  assign rdy       = rdy_q;
  assign ie        = ie_q;
  assign irq       = rdy_q & ie_q;
endmodule

// File: rtl/term_rdmux.sv
module term_rdmux
  import term_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [NUM_REGS-1:0]           rd_sel,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0]             rdata
);
  logic [NUM_REGS-1:0][DATA_W-1:0] gated;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_gate
    assign gated[g] = reg_val[g] & {DATA_W{rd_sel[g]}};
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) rdata = rdata | gated[i];
  end
endmodule

// File: rtl/term_mmio.sv
module term_mmio
  import term_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_data,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_data,
  input  logic              disp_ready,
  output logic              rx_irq,
  output logic              tx_irq
);
  localparam int unsigned PAD_W = BUS_W - CHAR_W;

  logic                          rst_sync_n;
  logic [NUM_REGS-1:0]           rd_sel;
  logic [NUM_REGS-1:0]           wr_sel;
  logic [NUM_REGS-1:0][BUS_W-1:0] reg_val;
  logic                          rx_rdy, rx_ie, rx_ovr;
  logic [CHAR_W-1:0]             rx_data;
  logic                          tx_rdy, tx_ie;

  term_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  term_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rd_sel   (rd_sel),
    .wr_sel   (wr_sel)
  );

  term_rx #(.CHAR_W(CHAR_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_valid    (kbd_valid),
    .in_data     (kbd_data),
    .rd_data_stb (rd_sel[SEL_RX_DATA]),
    .rd_stat_stb (rd_sel[SEL_RX_STAT]),
    .wr_stat_stb (wr_sel[SEL_RX_STAT]),
    .wr_ie       (bus_wdata[BIT_IE]),
    .rdy         (rx_rdy),
    .ie          (rx_ie),
    .ovr         (rx_ovr),
    .data        (rx_data),
    .irq         (rx_irq)
  );

  term_tx #(.CHAR_W(CHAR_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_data_stb (wr_sel[SEL_TX_DATA]),
    .wr_data     (bus_wdata[CHAR_W-1:0]),
    .wr_stat_stb (wr_sel[SEL_TX_STAT]),
    .wr_ie       (bus_wdata[BIT_IE]),
    .out_ready   (disp_ready),
    .out_valid   (disp_valid),
    .out_data    (disp_data),
    .rdy         (tx_rdy),
    .ie          (tx_ie),
    .irq         (tx_irq)
  );

  always_comb begin
    reg_val = '0;
    reg_val[SEL_RX_STAT][BIT_RDY] = rx_rdy;
    reg_val[SEL_RX_STAT][BIT_IE]  = rx_ie;
    reg_val[SEL_RX_STAT][BIT_OVR] = rx_ovr;
    reg_val[SEL_RX_DATA]          = {{PAD_W{1'b0}}, rx_data};
    reg_val[SEL_TX_STAT][BIT_RDY] = tx_rdy;
    reg_val[SEL_TX_STAT][BIT_IE]  = tx_ie;
    reg_val[SEL_TX_DATA]          = {{PAD_W{1'b0}}, disp_data};
  end

  term_rdmux #(.DATA_W(BUS_W)) u_mux (
    .rd_sel  (rd_sel),
    .reg_val (reg_val),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF0000
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              kbd_valid,
  input logic              disp_valid,
  input logic [CHAR_W-1:0] disp_data,
  input logic              disp_ready,
  input logic              rx_rdy,
  input logic              rx_ie,
  input logic              rx_ovr,
  input logic              tx_rdy,
  input logic              rx_irq
);
  localparam logic [ADDR_W-1:0] A_RXD = BASE_ADDR + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TXD = BASE_ADDR + ADDR_W'(12);

  logic rd_rxd, wr_txd;
  assign rd_rxd = bus_rd && (bus_addr == A_RXD);
  assign wr_txd = bus_wr && (bus_addr == A_TXD);

  AST_RX_ARRIVE_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kbd_valid |=> rx_rdy); // R3
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_rxd && !kbd_valid) |=> !rx_rdy); // R4
  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (kbd_valid && rx_rdy && !rd_rxd) |=> rx_ovr); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_data))); // R8
  AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (disp_valid && disp_ready) |=> (!disp_valid && tx_rdy)); // R7
  AST_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!disp_valid && !wr_txd) |=> !disp_valid); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rx_irq) |-> (rx_ie && rx_rdy)); // R9
endmodule

bind term_mmio term_mmio_chk #(
  .ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .kbd_valid  (kbd_valid),
  .disp_valid (disp_valid),
  .disp_data  (disp_data),
  .disp_ready (disp_ready),
  .rx_rdy     (rx_rdy),
  .rx_ie      (rx_ie),
  .rx_ovr     (rx_ovr),
  .tx_rdy     (tx_rdy),
  .rx_irq     (rx_irq)
);

// File: tb/term_mmio_tb.sv
`timescale 1ns/1ps
module term_mmio_tb;
  localparam logic [31:0] BASE = 32'hFFFF0000;
  localparam logic [31:0] A_RXS = BASE;
  localparam logic [31:0] A_RXD = BASE + 32'd4;
  localparam logic [31:0] A_TXS = BASE + 32'd8;
  localparam logic [31:0] A_TXD = BASE + 32'd12;

  logic        clk, rst_n;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr;
  logic        kbd_valid, disp_valid, disp_ready, rx_irq, tx_irq;
  logic [7:0]  kbd_data, disp_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  term_mmio u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid), .kbd_data(kbd_data), .disp_valid(disp_valid),
    .disp_data(disp_data), .disp_ready(disp_ready), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk);
    kbd_valid = 1'b1; kbd_data = c;
    @(negedge clk);
    kbd_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    kbd_valid = 1'b0; kbd_data = '0; disp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 disp_valid", {31'b0, disp_valid}, 32'd0);
    chk("R1 irqs", {30'b0, rx_irq, tx_irq}, 32'd0);
    rd_chk(A_RXS, 32'd0, "R1 rx status");
    rd_chk(A_TXS, 32'd1, "R1 tx status");

    // R3 R4 R10 sweep all codes through the input side
    for (int i = 0; i < 256; i++) begin
      key(8'(i));
      chk("R10 no echo", {31'b0, disp_valid}, 32'd0);
      rd_chk(A_RXS, 32'd1, "R3 ready set");
      rd_chk(A_RXD, 32'(i), "R3 data");
      rd_chk(A_RXS, 32'd0, "R4 ready cleared");
    end

    // R7 R8 sweep all codes through the output side
    for (int i = 0; i < 256; i++) begin
      wr(A_TXD, 32'hABCD_0000 | 32'(i));
      chk("R7 valid", {31'b0, disp_valid}, 32'd1);
      chk("R7 data", {24'b0, disp_data}, 32'(i));
      rd_chk(A_TXS, 32'd0, "R7 busy");
      wr(A_TXD, 32'(8'(i) ^ 8'hFF));
      chk("R8 ignored", {24'b0, disp_data}, 32'(i));
      rd_chk(A_TXD, 32'(i), "R8 readback");
      @(negedge clk); disp_ready = 1'b1;
      @(negedge clk); disp_ready = 1'b0;
      chk("R7 released", {31'b0, disp_valid}, 32'd0);
      rd_chk(A_TXS, 32'd1, "R7 ready again");
    end

    // R6 R9 interrupt enables
    wr(A_RXS, 32'hFFFF_FFFF);
    rd_chk(A_RXS, 32'd2, "R6 rx ie only");
    chk("R9 rx irq idle", {31'b0, rx_irq}, 32'd0);
    wr(A_TXS, 32'hFFFF_FFFF);
    rd_chk(A_TXS, 32'd3, "R6 tx ie");
    chk("R9 tx irq", {31'b0, tx_irq}, 32'd1);
    key(8'h41);
    chk("R9 rx irq", {31'b0, rx_irq}, 32'd1);
    rd_chk(A_RXD, 32'h41, "R3 data");
    chk("R9 rx irq off", {31'b0, rx_irq}, 32'd0);
    wr(A_TXD, 32'h5A);
    chk("R9 tx irq busy", {31'b0, tx_irq}, 32'd0);
    @(negedge clk); disp_ready = 1'b1;
    @(negedge clk); disp_ready = 1'b0;
    chk("R9 tx irq back", {31'b0, tx_irq}, 32'd1);
    wr(A_TXS, 32'd0);
    chk("R9 tx irq masked", {31'b0, tx_irq}, 32'd0);
    wr(A_RXS, 32'd0);

    // R5 overrun
    key(8'h11); key(8'h22);
    rd_chk(A_RXS, 32'd5, "R5 overrun set");
    rd_chk(A_RXS, 32'd1, "R5 overrun cleared");
    rd_chk(A_RXD, 32'h22, "R5 newest byte");

    // R4 arrival in same cycle as data read
    key(8'h33);
    @(negedge clk);
    bus_addr = A_RXD; bus_rd = 1'b1; kbd_valid = 1'b1; kbd_data = 8'h44;
    #1; chk("R4 old byte", bus_rdata, 32'h33);
    @(negedge clk); bus_rd = 1'b0; kbd_valid = 1'b0;
    rd_chk(A_RXS, 32'd1, "R4 ready kept, R5 no overrun");
    rd_chk(A_RXD, 32'h44, "R4 new byte");

    // R5 arrival wins over status-read clear
    key(8'h55);
    @(negedge clk);
    bus_addr = A_RXS; bus_rd = 1'b1; kbd_valid = 1'b1; kbd_data = 8'h66;
    #1; chk("R5 status before", bus_rdata, 32'd1);
    @(negedge clk); bus_rd = 1'b0; kbd_valid = 1'b0;
    rd_chk(A_RXS, 32'd5, "R5 set wins");
    rd_chk(A_RXD, 32'h66, "R5 data");

    // R2 decode
    rd_chk(BASE + 32'h10, 32'd0, "R2 unused read");
    rd_chk(BASE - 32'd4, 32'd0, "R2 below base");
    wr(BASE + 32'h1C, 32'hFFFF_FFFF);
    wr(32'h0000_0000, 32'hFFFF_FFFF);
    wr(32'h0000_000C, 32'h77);
    chk("R2 alias no tx", {31'b0, disp_valid}, 32'd0);
    rd_chk(A_RXS, 32'd0, "R2 rx status untouched");
    rd_chk(A_TXS, 32'd1, "R2 tx status untouched");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule